// File: doc/BRIEF.md
# Programmable Interlaced Video Timing Generator

This block generates the raster timing for a video output. A set of mode registers is loaded through a simple write port. The block then counts subsamples within a sample, samples within a line and lines within a frame. From that position it drives registered, active-high flags for horizontal sync, horizontal blanking, vertical sync, vertical blanking, field, active picture and an ancillary-data window. It also produces a one-clock start-of-frame marker at a programmable line, sample and subsample, and a pulse train at a programmable number of clocks. A programmable video-standard code is driven on its own output.

Progressive and interlaced formats are both supported. In interlaced mode, field 0 has its own vertical window, with its own start line, front porch, sync length and blanking length. The field flag changes at two programmable line numbers. All mode values are written into a shadow bank. The shadow bank is copied into the active bank only at the end of a frame, or on every clock while the generator is stopped. A running raster therefore never changes timing in the middle of a frame.

Each sample lasts `SUBS` clocks (1 to 4, default 2). All flags are registered one clock behind the counter position they describe.

Top module: `vid_raster_gen`

## Requirements
- R1: While the active bank's run bit (control register address 0, bit 0) is 0, all timing flags and the divided-clock pulse are 0 and the counters stay at zero. This includes the state after reset, which clears both banks.
- R2: A write lands in the shadow bank. The active bank takes the shadow values at the last clock of a frame, or on the next clock when the run bit of the active bank is 0. Register addresses are: 0 control (bit 0 run, bit 1 interlaced), 1 samples per line, 2 lines per frame, 3 horizontal sync length, 4 horizontal blanking length, 5 vertical front porch, 6 vertical sync length, 7 vertical blanking length, 8 field-0 front porch, 9 field-0 sync length, 10 field-0 blanking length, 11 first active line, 12 field-0 blanking start line, 13 field set line, 14 field clear line, 15 standard code, 16 start-of-frame position, 17 start-of-frame line, 18 divider, 19 ancillary line.
- R3: A line lasts the programmed number of samples, and each sample lasts `SUBS` clocks. Horizontal sync is high for samples below the sync length. Horizontal blanking is high for samples below the blanking length.
- R4: Lines run from 0 to lines-per-frame minus 1. Vertical blanking is high on lines below the blanking length. Vertical sync is high from line front-porch for sync-length lines.
- R5: In interlaced mode, a second window also applies. Blanking is high from the field-0 start line for the field-0 blanking length. Sync is high from start plus field-0 front porch for the field-0 sync length. In progressive mode the field-0 registers have no effect.
- R6: Active picture is high when neither blanking flag is high and the line is at or past the first active line.
- R7: In progressive mode the field flag is 0. In interlaced mode it goes to 1 at the first clock of the field set line and to 0 at the first clock of the field clear line, and it holds otherwise. The set line wins if both lines are equal. The flag starts at 0 each time the generator leaves the stopped state.
- R8: The start-of-frame output is high for exactly one clock when the position matches. The matching sample is bits 15:2 of the start-of-frame position register, and the matching subsample is bits 1:0.
- R9: The start-of-frame line is the programmed offset added to the line where vertical sync rises, reduced once by lines-per-frame if the sum reaches it. That sync line is the front porch in progressive mode, and field-0 start plus field-0 front porch in interlaced mode.
- R10: The divided-clock pulse is high once every N clocks while running, with N the divider value. N of 0 or 1 gives a pulse on every clock. The count restarts when the generator starts.
- R11: The standard-code output always equals the active bank's 8-bit standard code.
- R12: The ancillary-window flag is high on every line at or past the ancillary line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 5 | Register address |
| wrData | input | 16 | Register write data |
| hSyncOut | output | 1 | Horizontal sync |
| hBlankOut | output | 1 | Horizontal blanking |
| vSyncOut | output | 1 | Vertical sync |
| vBlankOut | output | 1 | Vertical blanking |
| activeOut | output | 1 | Active picture |
| fieldOut | output | 1 | Field indicator |
| sofOut | output | 1 | Start-of-frame pulse |
| ancOut | output | 1 | Ancillary-data window |
| divClkPulse | output | 1 | Divided-clock pulse |
| stdCodeOut | output | 8 | Video-standard code |

## Verification
A behavioural raster model in the bench is compared with every output on every clock. The design is tried with three mode patterns:
- A progressive raster with non-zero field-0 registers. This separates the field-0 window from the normal one and shows that field-0 values are ignored in this mode.
- An interlaced raster whose start-of-frame line wraps past the end of the frame. This tells the modular line arithmetic apart from a plain offset.
- A restart after a stop. This tells frame-aligned bank loading apart from immediate loading.

Divider values of 0, 1, 5 and 7 separate the pulse-every-clock case from real division. Writes made in the middle of a frame show whether a register change waits for the frame boundary.

// File: rtl/vrg_pkg.sv
package vrg_pkg;
  localparam int SMP_W  = 14;  // sample index width
  localparam int LN_W   = 12;  // line index width
  localparam int STD_W  = 8;   // standard code width
  localparam int DIV_W  = 16;  // divider width
  localparam int SUB_W  = 2;   // subsample field width
  localparam int ADDR_W = 5;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL     = 5'd0,  RA_LINE_SMP = 5'd1,  RA_FRAME_LN = 5'd2,
    RA_HSYNC    = 5'd3,  RA_HBLANK   = 5'd4,  RA_VFP      = 5'd5,
    RA_VSYNC    = 5'd6,  RA_VBLANK   = 5'd7,  RA_F0_FP    = 5'd8,
    RA_F0_SYNC  = 5'd9,  RA_F0_BLANK = 5'd10, RA_ACT_LN   = 5'd11,
    RA_F0_START = 5'd12, RA_FLD_SET  = 5'd13, RA_FLD_CLR  = 5'd14,
    RA_STD      = 5'd15, RA_SOF_POS  = 5'd16, RA_SOF_LN   = 5'd17,
    RA_DIV      = 5'd18, RA_ANC_LN   = 5'd19
  } regAddr_t;

  typedef struct packed {
    logic              valid;
    logic              interlaced;
    logic [SMP_W-1:0]  lineSamples;
    logic [SMP_W-1:0]  hSyncLen;
    logic [SMP_W-1:0]  hBlankLen;
    logic [SMP_W-1:0]  sofSample;
    logic [SUB_W-1:0]  sofSub;
    logic [LN_W-1:0]   frameLines;
    logic [LN_W-1:0]   vFrontPorch;
    logic [LN_W-1:0]   vSyncLen;
    logic [LN_W-1:0]   vBlankLen;
    logic [LN_W-1:0]   f0FrontPorch;
    logic [LN_W-1:0]   f0SyncLen;
    logic [LN_W-1:0]   f0BlankLen;
    logic [LN_W-1:0]   activeLine;
    logic [LN_W-1:0]   f0BlankStart;
    logic [LN_W-1:0]   fieldRise;
    logic [LN_W-1:0]   fieldFall;
    logic [LN_W-1:0]   sofLine;
    logic [LN_W-1:0]   ancLine;
    logic [STD_W-1:0]  stdCode;
    logic [DIV_W-1:0]  divider;
  } modeBank_t;

  typedef struct packed {
    logic run;
    logic lineStart;
  } vrgStrobe_t;
endpackage

// File: rtl/vrg_regs.sv
module vrg_regs
  import vrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              frameEnd,
  output modeBank_t         actBank
);
  modeBank_t shadow;
  logic      loadBank;

  assign loadBank = !actBank.valid || frameEnd;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        RA_CTRL: begin
          shadow.valid      <= wrData[0];
          shadow.interlaced <= wrData[1];
        end
        RA_LINE_SMP: shadow.lineSamples  <= wrData[SMP_W-1:0];
        RA_FRAME_LN: shadow.frameLines   <= wrData[LN_W-1:0];
        RA_HSYNC:    shadow.hSyncLen     <= wrData[SMP_W-1:0];
        RA_HBLANK:   shadow.hBlankLen    <= wrData[SMP_W-1:0];
        RA_VFP:      shadow.vFrontPorch  <= wrData[LN_W-1:0];
        RA_VSYNC:    shadow.vSyncLen     <= wrData[LN_W-1:0];
        RA_VBLANK:   shadow.vBlankLen    <= wrData[LN_W-1:0];
        RA_F0_FP:    shadow.f0FrontPorch <= wrData[LN_W-1:0];
        RA_F0_SYNC:  shadow.f0SyncLen    <= wrData[LN_W-1:0];
        RA_F0_BLANK: shadow.f0BlankLen   <= wrData[LN_W-1:0];
        RA_ACT_LN:   shadow.activeLine   <= wrData[LN_W-1:0];
        RA_F0_START: shadow.f0BlankStart <= wrData[LN_W-1:0];
        RA_FLD_SET:  shadow.fieldRise    <= wrData[LN_W-1:0];
        RA_FLD_CLR:  shadow.fieldFall    <= wrData[LN_W-1:0];
        RA_STD:      shadow.stdCode      <= wrData[STD_W-1:0];
        RA_SOF_POS: begin
          shadow.sofSub    <= wrData[SUB_W-1:0];
          shadow.sofSample <= wrData[SMP_W+SUB_W-1:SUB_W];
        end
        RA_SOF_LN:   shadow.sofLine      <= wrData[LN_W-1:0];
        RA_DIV:      shadow.divider      <= wrData[DIV_W-1:0];
        RA_ANC_LN:   shadow.ancLine      <= wrData[LN_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           actBank <= '0;
    else if (loadBank) actBank <= shadow;
  end

  // R2: a running bank only changes at the frame boundary reported by the counters
  a_r2_bank_hold: assert property (@(posedge clk) disable iff (rst)
    (actBank.valid && !frameEnd) |=> $stable(actBank));
endmodule

// File: rtl/vrg_ctrl.sv
module vrg_ctrl
  import vrg_pkg::*;
#(
  parameter int SUBS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             modeValid,
  input  logic [SMP_W-1:0] lineSamples,
  input  logic [LN_W-1:0]  frameLines,
  input  logic [DIV_W-1:0] divider,
  output vrgStrobe_t       strb,
  output logic [SUB_W-1:0] subCnt,
  output logic [SMP_W-1:0] sampleCnt,
  output logic [LN_W-1:0]  lineCnt,
  output logic             frameEnd,
  output logic             divPulse
);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(SUBS - 1);

  logic             lastSub, lastSample, lastLine, divHit;
  logic [DIV_W-1:0] divCnt;

  assign lastSub    = subCnt >= SUB_LAST;
  assign lastSample = ({1'b0, sampleCnt} + 1'b1) >= {1'b0, lineSamples};
  assign lastLine   = ({1'b0, lineCnt} + 1'b1) >= {1'b0, frameLines};
  assign frameEnd   = modeValid && lastSub && lastSample && lastLine;
  assign divHit     = ({1'b0, divCnt} + 1'b1) >= {1'b0, divider};

  assign strb.run       = modeValid;
  assign strb.lineStart = (subCnt == '0) && (sampleCnt == '0);

  always_ff @(posedge clk) begin
    if (rst || !modeValid) begin
      subCnt    <= '0;
      sampleCnt <= '0;
      lineCnt   <= '0;
    end else begin
      subCnt <= lastSub ? '0 : subCnt + 1'b1;
      if (lastSub) begin
        sampleCnt <= lastSample ? '0 : sampleCnt + 1'b1;
        if (lastSample) lineCnt <= lastLine ? '0 : lineCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !modeValid) begin
      divCnt   <= '0;
      divPulse <= 1'b0;
    end else begin
      divPulse <= divHit;
      divCnt   <= divHit ? '0 : divCnt + 1'b1;
    end
  end

  // R3: sample index never leaves the programmed line
  a_r3_sample_bound: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (sampleCnt < lineSamples || lineSamples == '0));
  // R4: line index never leaves the programmed frame
  a_r4_line_bound: assert property (@(posedge clk) disable iff (rst)
    strb.run |-> (lineCnt < frameLines || frameLines == '0));
  // R10: with a divider above one, pulses are never back to back
  a_r10_div_gap: assert property (@(posedge clk) disable iff (rst)
    (divPulse && divider > 1) |=> !divPulse);
endmodule

// File: rtl/vrg_dpath.sv
module vrg_dpath
  import vrg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  vrgStrobe_t       strb,
  input  modeBank_t        bank,
  input  logic [SUB_W-1:0] subCnt,
  input  logic [SMP_W-1:0] sampleCnt,
  input  logic [LN_W-1:0]  lineCnt,
  output logic             hSyncOut,
  output logic             hBlankOut,
  output logic             vSyncOut,
  output logic             vBlankOut,
  output logic             activeOut,
  output logic             fieldOut,
  output logic             sofOut,
  output logic             ancOut
);
  localparam int SUM_W = LN_W + 2;
  localparam int NWIN  = 2;  // window 0: normal/field 1, window 1: field 0

  logic [SUM_W-1:0] lineExt;
  logic [SUM_W-1:0] winStart [NWIN];
  logic [SUM_W-1:0] winFp    [NWIN];
  logic [SUM_W-1:0] winSync  [NWIN];
  logic [SUM_W-1:0] winLen   [NWIN];
  logic [SUM_W-1:0] syncRise [NWIN];
  logic [NWIN-1:0]  winOn, inBlank, inSync;

  logic             hSyncNx, hBlankNx, vBlankNx, fieldNx, sofNx;
  logic [SUM_W-1:0] sofSum, sofAbs;
  logic             unusedBank;

  assign unusedBank = ^{bank.valid, bank.lineSamples, bank.stdCode, bank.divider};
  assign lineExt    = SUM_W'(lineCnt);

  always_comb begin
    winStart[0] = '0;
    winFp[0]    = SUM_W'(bank.vFrontPorch);
    winSync[0]  = SUM_W'(bank.vSyncLen);
    winLen[0]   = SUM_W'(bank.vBlankLen);
    winStart[1] = SUM_W'(bank.f0BlankStart);
    winFp[1]    = SUM_W'(bank.f0FrontPorch);
    winSync[1]  = SUM_W'(bank.f0SyncLen);
    winLen[1]   = SUM_W'(bank.f0BlankLen);
  end

  assign winOn = {bank.interlaced, 1'b1};

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign syncRise[w] = winStart[w] + winFp[w];
    assign inBlank[w]  = winOn[w] && (lineExt >= winStart[w]) &&
                         (lineExt < winStart[w] + winLen[w]);
    assign inSync[w]   = winOn[w] && (lineExt >= syncRise[w]) &&
                         (lineExt < syncRise[w] + winSync[w]);
  end

  assign hSyncNx  = sampleCnt < bank.hSyncLen;
  assign hBlankNx = sampleCnt < bank.hBlankLen;
  assign vBlankNx = |inBlank;

  always_comb begin
    sofSum = (bank.interlaced ? syncRise[1] : syncRise[0]) + SUM_W'(bank.sofLine);
    sofAbs = (sofSum >= SUM_W'(bank.frameLines)) ? sofSum - SUM_W'(bank.frameLines) : sofSum;
  end
  assign sofNx = (lineExt == sofAbs) && (sampleCnt == bank.sofSample) &&
                 (subCnt == bank.sofSub);

  always_comb begin
    fieldNx = fieldOut;
    if (!bank.interlaced)                                fieldNx = 1'b0;
    else if (strb.lineStart && lineCnt == bank.fieldRise) fieldNx = 1'b1;
    else if (strb.lineStart && lineCnt == bank.fieldFall) fieldNx = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst || !strb.run) begin
      hSyncOut  <= 1'b0;
      hBlankOut <= 1'b0;
      vSyncOut  <= 1'b0;
      vBlankOut <= 1'b0;
      activeOut <= 1'b0;
      fieldOut  <= 1'b0;
      sofOut    <= 1'b0;
      ancOut    <= 1'b0;
    end else begin
      hSyncOut  <= hSyncNx;
      hBlankOut <= hBlankNx;
      vSyncOut  <= |inSync;
      vBlankOut <= vBlankNx;
      activeOut <= !hBlankNx && !vBlankNx && (lineCnt >= bank.activeLine);
      fieldOut  <= fieldNx;
      sofOut    <= sofNx;
      ancOut    <= lineCnt >= bank.ancLine;
    end
  end

  // R1: a stopped generator drives quiet flags on the next clock
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !strb.run |=> !(hSyncOut || hBlankOut || vSyncOut || vBlankOut ||
                    activeOut || fieldOut || sofOut || ancOut));
  // R8: start-of-frame is a single-clock pulse
  a_r8_sof_single: assert property (@(posedge clk) disable iff (rst)
    sofOut |=> !sofOut);
  // R7: progressive mode keeps field at 0
  a_r7_field_prog: assert property (@(posedge clk) disable iff (rst)
    (strb.run && !bank.interlaced) |=> !fieldOut);
  // R7: field only changes at a line start
  a_r7_field_hold: assert property (@(posedge clk) disable iff (rst)
    (strb.run && bank.interlaced && !strb.lineStart) |=> $stable(fieldOut));
endmodule

// File: rtl/vid_raster_gen.sv
module vid_raster_gen
  import vrg_pkg::*;
#(
  parameter int SUBS = 2  // clocks per sample, 1 to 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              hSyncOut,
  output logic              hBlankOut,
  output logic              vSyncOut,
  output logic              vBlankOut,
  output logic              activeOut,
  output logic              fieldOut,
  output logic              sofOut,
  output logic              ancOut,
  output logic              divClkPulse,
  output logic [STD_W-1:0]  stdCodeOut
);
  modeBank_t        actBank;
  vrgStrobe_t       strb;
  logic [SUB_W-1:0] subCnt;
  logic [SMP_W-1:0] sampleCnt;
  logic [LN_W-1:0]  lineCnt;
  logic             frameEnd;

  vrg_regs u_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .frameEnd(frameEnd), .actBank(actBank)
  );

  vrg_ctrl #(.SUBS(SUBS)) u_ctrl (
    .clk(clk), .rst(rst), .modeValid(actBank.valid),
    .lineSamples(actBank.lineSamples), .frameLines(actBank.frameLines),
    .divider(actBank.divider), .strb(strb), .subCnt(subCnt),
    .sampleCnt(sampleCnt), .lineCnt(lineCnt), .frameEnd(frameEnd),
    .divPulse(divClkPulse)
  );

  vrg_dpath u_dpath (
    .clk(clk), .rst(rst), .strb(strb), .bank(actBank), .subCnt(subCnt),
    .sampleCnt(sampleCnt), .lineCnt(lineCnt), .hSyncOut(hSyncOut),
    .hBlankOut(hBlankOut), .vSyncOut(vSyncOut), .vBlankOut(vBlankOut),
    .activeOut(activeOut), .fieldOut(fieldOut), .sofOut(sofOut), .ancOut(ancOut)
  );

  assign stdCodeOut = actBank.stdCode;
endmodule

// File: tb/vid_raster_gen_bench.sv
`timescale 1ns/1ps
module vid_raster_gen_bench;
  localparam int SUBS = 2;
  localparam int NREG = 20;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [4:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic hSyncOut, hBlankOut, vSyncOut, vBlankOut, activeOut, fieldOut, sofOut, ancOut, divClkPulse;
  logic [7:0] stdCodeOut;

  always #2.5 clk = ~clk;

  vid_raster_gen #(.SUBS(SUBS)) u_vid_raster_gen (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hSyncOut(hSyncOut), .hBlankOut(hBlankOut), .vSyncOut(vSyncOut),
    .vBlankOut(vBlankOut), .activeOut(activeOut), .fieldOut(fieldOut),
    .sofOut(sofOut), .ancOut(ancOut), .divClkPulse(divClkPulse),
    .stdCodeOut(stdCodeOut)
  );

  int nCmp = 0, nBad = 0, cyc = 0;
  bit done = 0;
  int sh [NREG];
  int ac [NREG];
  int ln, smp, sb, dcnt, ss, sl;
  bit run, il, ls, fend;
  bit eH, eHB, eV, eVB, eAct, eFld, eSof, eAnc, eDiv;

  function automatic int regMask(int a);
    case (a)
      0: return 3;
      1, 3, 4: return 'h3fff;
      15: return 'hff;
      16, 18: return 'hffff;
      default: return 'hfff;
    endcase
  endfunction

  task automatic chk(int act, int exp, string tag);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference raster model: outputs describe the pre-edge position
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) begin sh[i] = 0; ac[i] = 0; end
      ln = 0; smp = 0; sb = 0; dcnt = 0;
      {eH, eHB, eV, eVB, eAct, eFld, eSof, eAnc, eDiv} = '0;
    end else begin
      run = ac[0][0];
      fend = 0;
      if (run) begin
        il = ac[0][1];
        ls = (smp == 0) && (sb == 0);
        eH  = smp < ac[3];
        eHB = smp < ac[4];
        eVB = (ln < ac[7]) || (il && ln >= ac[12] && ln < ac[12] + ac[10]);
        eV  = (ln >= ac[5] && ln < ac[5] + ac[6]) ||
              (il && ln >= ac[12] + ac[8] && ln < ac[12] + ac[8] + ac[9]);
        eAct = !eHB && !eVB && ln >= ac[11];
        if (!il) eFld = 0;
        else if (ls && ln == ac[13]) eFld = 1;
        else if (ls && ln == ac[14]) eFld = 0;
        ss = il ? ac[12] + ac[8] : ac[5];
        sl = ss + ac[17];
        if (sl >= ac[2]) sl = sl - ac[2];
        eSof = (ln == sl) && (smp == (ac[16] >> 2)) && (sb == (ac[16] & 3));
        eAnc = ln >= ac[19];
        eDiv = (dcnt + 1) >= ac[18];
        dcnt = eDiv ? 0 : dcnt + 1;
        if (sb >= SUBS - 1) begin
          sb = 0;
          if (smp + 1 >= ac[1]) begin
            smp = 0;
            if (ln + 1 >= ac[2]) begin ln = 0; fend = 1; end
            else ln = ln + 1;
          end else smp = smp + 1;
        end else sb = sb + 1;
      end else begin
        ln = 0; smp = 0; sb = 0; dcnt = 0;
        {eH, eHB, eV, eVB, eAct, eFld, eSof, eAnc, eDiv} = '0;
      end
      if (!run || fend)
        for (int i = 0; i < NREG; i++) ac[i] = sh[i];
      if (wrEn && wrAddr < NREG) sh[wrAddr] = wrData & regMask(wrAddr);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(hSyncOut,    eH,   "R3 hSync");
      chk(hBlankOut,   eHB,  "R3 hBlank");
      chk(vSyncOut,    eV,   "R4/R5 vSync");
      chk(vBlankOut,   eVB,  "R4/R5 vBlank");
      chk(activeOut,   eAct, "R6 active");
      chk(fieldOut,    eFld, "R7 field");
      chk(sofOut,      eSof, "R8/R9 sof");
      chk(ancOut,      eAnc, "R12 anc");
      chk(divClkPulse, eDiv, "R10 divider");
      chk(stdCodeOut,  ac[15], "R11 std code");
    end
  end

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      nBad++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); wrEn = 1'b1; wrAddr = 5'(a); wrData = 16'(d);
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic idleCheck(string tag);
    chk(int'({hSyncOut, hBlankOut, vSyncOut, vBlankOut, activeOut,
              fieldOut, sofOut, ancOut, divClkPulse}), 0, tag);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    idleCheck("R1 idle after reset");

    // progressive mode; field-0 registers loaded but must have no effect (R5)
    wr(1, 20); wr(2, 12); wr(3, 3); wr(4, 6);
    wr(5, 1); wr(6, 2); wr(7, 4);
    wr(8, 1); wr(9, 2); wr(10, 3); wr(12, 6);
    wr(11, 4); wr(13, 2); wr(14, 8);
    wr(15, 'h5A); wr(16, (7 << 2) | 1); wr(17, 3); wr(18, 7); wr(19, 9);
    repeat (3) @(negedge clk);
    idleCheck("R1 idle while run bit clear");
    wr(0, 1);
    repeat (1000) @(negedge clk);

    // mid-frame writes wait for the frame boundary (R2)
    while (!sofOut) @(negedge clk);
    wr(15, 'h33); wr(3, 5);
    repeat (3) @(negedge clk);
    chk(stdCodeOut, 'h5A, "R2 shadow held until frame end");
    repeat (500) @(negedge clk);
    chk(stdCodeOut, 'h33, "R2 shadow applied after frame end");

    // interlaced mode with wrapping start-of-frame line (R5, R7, R9)
    wr(1, 16); wr(2, 20); wr(3, 2); wr(4, 4);
    wr(5, 1); wr(6, 1); wr(7, 3);
    wr(8, 1); wr(9, 1); wr(10, 3); wr(12, 10);
    wr(11, 2); wr(13, 10); wr(14, 0);
    wr(16, (5 << 2) | 0); wr(17, 12); wr(18, 1); wr(19, 15);
    wr(0, 3);
    repeat (2000) @(negedge clk);
    wr(18, 0);
    repeat (700) @(negedge clk);

    // stop mid-frame: runs to frame end, then goes quiet (R1, R2)
    wr(0, 0);
    repeat (1000) @(negedge clk);
    idleCheck("R1 idle after stop");

    // restart progressive with divider 5
    wr(18, 5); wr(17, 11); wr(0, 1);
    repeat (1500) @(negedge clk);
    finishRun();
  end
endmodule